// File: doc/BRIEF.md
# Multi-Aperture Pixel Store with Per-Pixel Display Modes

This block holds the pixels of a frame buffer. Every pixel keeps 24 colour bits (blue, green and red) and a 2-bit display-mode field, 26 stored bits in all. A simple single-request bus reaches the same storage through three apertures. The full-word aperture shows the mode field above the colour. The 24-bit aperture hides the mode field, so software can paint colour without disturbing the modes. The packed byte aperture gives one byte per pixel and touches only the low colour byte, which carries the palette index in 8-bit operation.

A separate scan-out port reads one pixel per request with a fixed one-cycle latency. It never waits on bus traffic. It returns the 24 colour bits together with a decoded mode that tells the next stage whether to use the low byte as a palette index, send all 24 bits through the palette, or use them as direct levels. The pixel array size, colour width and index width are parameters. Stored mode bits are not initialised at reset, so every pixel has to be written before it is scanned.

Top module: `pxs_pixel_store`

## Requirements
- R1: With `bus_ap`=2 (full-word aperture) and `bus_word`=1, pixel index = `bus_addr`>>2 and `bus_addr`[1:0] is ignored. A write stores `bus_wdata`[25:0] (colour in [23:0], mode in [25:24]) and ignores [31:26]. A read returns the 26 stored bits in [25:0] with [31:26] zero.
- R2: With `bus_ap`=1 (24-bit aperture) and `bus_word`=1, pixel index = `bus_addr`>>2. A read returns the colour in [23:0] with [31:24] zero. A write updates only colour bits [23:0] and leaves the stored mode bits unchanged.
- R3: With `bus_ap`=0 (byte aperture) and `bus_word`=0, pixel index = `bus_addr`. A write changes only stored bits [7:0], taken from `bus_wdata`[7:0], and leaves the other 18 bits unchanged. A read returns those bits in [7:0] with [31:8] zero.
- R4: `scan_mode` decodes the stored mode field as follows: 00 gives 0 (palette index in low byte), 01 gives 1 (24 bits through palette), 11 gives 2 (direct levels), and the reserved code 10 gives 0. The value 3 never appears.
- R5: A `scan_req` in one cycle gives `scan_valid`=1 in the next cycle, with `scan_color` equal to the stored 24 colour bits of `scan_idx`. This holds in every cycle, whatever bus traffic runs at the same time.
- R6: When the bus writes the pixel that a scan request reads in the same cycle, the scan returns the value stored before that write. A later scan sees the new value.
- R7: An access whose address lies outside the selected aperture reads zero and its write is dropped. The byte aperture spans NPIX addresses and each word aperture spans 4*NPIX addresses. `bus_ap`=3 selects no aperture, so every access through it is out of range.
- R8: An access whose size does not fit the aperture (`bus_word`=1 on the byte aperture, or `bus_word`=0 on a word aperture) is treated as out of range: it reads zero and its write is dropped.
- R9: A bus read (`bus_req`=1, `bus_we`=0) gives `bus_rvalid`=1 in the next cycle, with data in `bus_rdata`. Writes produce no `bus_rvalid`. `bus_rdata` is zero whenever no in-range read completes. After reset, `bus_rvalid`, `scan_valid` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of control registers |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ap | input | 2 | Aperture: 0 byte, 1 24-bit, 2 full word, 3 none |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_addr | input | AW (12) | Byte address within the aperture |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read completes this cycle |
| scan_req | input | 1 | Scan-out read request |
| scan_idx | input | IW (10) | Pixel index to scan |
| scan_valid | output | 1 | Scan result valid |
| scan_color | output | 24 | Stored colour of the scanned pixel |
| scan_mode | output | 2 | Decoded display mode |

## Verification
The array is first filled through the full-word aperture with all four mode codes and junk above bit 25. Every pixel is then scanned, which separates a correct mode decode (including the reserved code) from any shifted or truncated field. The same pixels are read back through all three apertures, which shows whether each aperture masks and places its field correctly. Writes through the narrow apertures with all-ones upper data are followed by full-word reads, which expose any lane that is written when it should be left alone. Out-of-range and mismatched-size accesses are followed by readback of the pixels they could alias. Scans run alongside bus reads and writes, including writes to the pixel being scanned, which separates read-before-write from write-through and shows any stall.

// File: rtl/pxs_pkg.sv
`timescale 1ns/1ps
package pxs_pkg;
   // aperture select codes on the bus
   typedef enum logic [1:0] {
      AP_BYTE = 2'd0,
      AP_W24  = 2'd1,
      AP_W32  = 2'd2,
      AP_NONE = 2'd3
   } ap_e;

   // decoded display mode delivered with scan-out data
   typedef enum logic [1:0] {
      SM_INDEX8   = 2'd0,
      SM_MAPPED24 = 2'd1,
      SM_DIRECT24 = 2'd2
   } scan_mode_e;

   // storage is split into independently writable lanes
   localparam int NLANE    = 3;
   localparam int LANE_IDX = 0;   // low colour byte / palette index
   localparam int LANE_HI  = 1;   // upper colour bits
   localparam int LANE_MOD = 2;   // per-pixel mode field
   localparam int DATA_W   = 32;
endpackage

// File: rtl/pxs_ap_decode.sv
`timescale 1ns/1ps
module pxs_ap_decode
   import pxs_pkg::*;
#(
   parameter int NPIX = 768,
   localparam int IW  = $clog2(NPIX),
   localparam int AW  = IW + 2
) (
   input  ap_e               ap,
   input  logic              word,
   input  logic [AW-1:0]     addr,
   output logic              hit,
   output logic [IW-1:0]     idx,
   output logic [NLANE-1:0]  lane_we
);
   localparam logic [AW:0] BYTE_SPAN = (AW+1)'(NPIX);
   localparam logic [AW:0] WORD_SPAN = (AW+1)'(4 * NPIX);

   logic byte_in, word_in;
   assign byte_in = ({1'b0, addr} < BYTE_SPAN);
   assign word_in = ({1'b0, addr} < WORD_SPAN);

   always_comb begin
      hit     = 1'b0;
      idx     = addr[IW+1:2];
      lane_we = '0;
      unique case (ap)
         AP_BYTE: begin
            hit     = !word && byte_in;
            idx     = addr[IW-1:0];
            lane_we = NLANE'(1) << LANE_IDX;
         end
         AP_W24: begin
            hit     = word && word_in;
            lane_we = (NLANE'(1) << LANE_IDX) | (NLANE'(1) << LANE_HI);
         end
         AP_W32: begin
            hit     = word && word_in;
            lane_we = '1;
         end
         default: begin
            hit     = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/pxs_lane_store.sv
`timescale 1ns/1ps
module pxs_lane_store
   import pxs_pkg::*;
#(
   parameter int NPIX     = 768,
   parameter int IDX_BITS = 8,
   parameter int COLOR_W  = 24,
   parameter int MODE_W   = 2,
   localparam int IW      = $clog2(NPIX),
   localparam int SW      = COLOR_W + MODE_W
) (
   input  logic              clk,
   // port A: bus side, read or write
   input  logic              a_en,
   input  logic              a_we,
   input  logic [IW-1:0]     a_idx,
   input  logic [NLANE-1:0]  a_lane_we,
   input  logic [SW-1:0]     a_wdata,
   output logic [SW-1:0]     a_q,
   // port B: scan-out, read only
   input  logic              b_en,
   input  logic [IW-1:0]     b_idx,
   output logic [SW-1:0]     b_q
);
   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int LO = (g == LANE_IDX) ? 0 :
                          (g == LANE_HI)  ? IDX_BITS : COLOR_W;
      localparam int LW = (g == LANE_IDX) ? IDX_BITS :
                          (g == LANE_HI)  ? (COLOR_W - IDX_BITS) : MODE_W;

      logic [LW-1:0] mem [NPIX];
      logic [LW-1:0] qa, qb;

      always_ff @(posedge clk) begin
         if (a_en && a_we && a_lane_we[g])
            mem[a_idx] <= a_wdata[LO +: LW];
         if (a_en && !a_we)
            qa <= mem[a_idx];
      end

      // read-before-write against port A by nonblocking semantics
      always_ff @(posedge clk) begin
         if (b_en)
            qb <= mem[b_idx];
      end

      assign a_q[LO +: LW] = qa;
      assign b_q[LO +: LW] = qb;
   end
endmodule

// File: rtl/pxs_mode_decode.sv
`timescale 1ns/1ps
module pxs_mode_decode
   import pxs_pkg::*;
(
   input  logic [1:0] code,
   output scan_mode_e mode
);
   always_comb begin
      unique case (code)
         2'b01:   mode = SM_MAPPED24;
         2'b11:   mode = SM_DIRECT24;
         default: mode = SM_INDEX8;   // 00 and reserved 10
      endcase
   end
endmodule

// File: rtl/pxs_pixel_store.sv
`timescale 1ns/1ps
module pxs_pixel_store
   import pxs_pkg::*;
#(
   parameter int H_PIX    = 32,
   parameter int V_PIX    = 24,
   parameter int IDX_BITS = 8,
   parameter int COLOR_W  = 24,
   parameter int MODE_W   = 2,
   localparam int NPIX    = H_PIX * V_PIX,
   localparam int IW      = $clog2(NPIX),
   localparam int AW      = IW + 2,
   localparam int SW      = COLOR_W + MODE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [1:0]         bus_ap,
   input  logic               bus_word,
   input  logic [AW-1:0]      bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               bus_rvalid,
   input  logic               scan_req,
   input  logic [IW-1:0]      scan_idx,
   output logic               scan_valid,
   output logic [COLOR_W-1:0] scan_color,
   output logic [1:0]         scan_mode
);
   // elaboration-time parameter checks
   if (MODE_W != 2)
      $error("pxs_pixel_store: MODE_W must be 2");
   if (SW > DATA_W)
      $error("pxs_pixel_store: colour plus mode exceeds bus width");
   if (IDX_BITS < 1 || IDX_BITS >= COLOR_W)
      $error("pxs_pixel_store: IDX_BITS must be below COLOR_W");
   if (NPIX < 2)
      $error("pxs_pixel_store: pixel array too small");

   logic              hit;
   logic [IW-1:0]     idx;
   logic [NLANE-1:0]  lane_we;
   logic [SW-1:0]     a_q, b_q;
   logic              rd_hit_q;
   ap_e               rd_ap_q;
   scan_mode_e        smode;
   logic              unused_wtop;

   assign unused_wtop = ^bus_wdata[DATA_W-1:SW];

   pxs_ap_decode #(.NPIX(NPIX)) dec_i (
      .ap      (ap_e'(bus_ap)),
      .word    (bus_word),
      .addr    (bus_addr),
      .hit     (hit),
      .idx     (idx),
      .lane_we (lane_we)
   );

   pxs_lane_store #(
      .NPIX     (NPIX),
      .IDX_BITS (IDX_BITS),
      .COLOR_W  (COLOR_W),
      .MODE_W   (MODE_W)
   ) store_i (
      .clk       (clk),
      .a_en      (bus_req && hit),
      .a_we      (bus_we),
      .a_idx     (idx),
      .a_lane_we (lane_we),
      .a_wdata   (bus_wdata[SW-1:0]),
      .a_q       (a_q),
      .b_en      (scan_req),
      .b_idx     (scan_idx),
      .b_q       (b_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         rd_hit_q   <= 1'b0;
         rd_ap_q    <= AP_NONE;
         scan_valid <= 1'b0;
      end else begin
         bus_rvalid <= bus_req && !bus_we;
         rd_hit_q   <= bus_req && !bus_we && hit;
         rd_ap_q    <= ap_e'(bus_ap);
         scan_valid <= scan_req;
      end
   end

   // shape read data for the aperture that issued the read
   always_comb begin
      bus_rdata = '0;
      if (rd_hit_q) begin
         unique case (rd_ap_q)
            AP_BYTE: bus_rdata = DATA_W'(a_q[IDX_BITS-1:0]);
            AP_W24:  bus_rdata = DATA_W'(a_q[COLOR_W-1:0]);
            AP_W32:  bus_rdata = DATA_W'(a_q);
            default: bus_rdata = '0;
         endcase
      end
   end

   pxs_mode_decode mdec_i (
      .code (b_q[SW-1:COLOR_W]),
      .mode (smode)
   );

   assign scan_color = b_q[COLOR_W-1:0];
   assign scan_mode  = smode;
endmodule

// File: rtl/pxs_pixel_store_chk.sv
`timescale 1ns/1ps
module pxs_pixel_store_chk #(
   parameter int AW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_we,
   input logic [1:0]    bus_ap,
   input logic          bus_word,
   input logic [AW-1:0] bus_addr,
   input logic [31:0]   bus_rdata,
   input logic          bus_rvalid,
   input logic          scan_req,
   input logic          scan_valid,
   input logic [1:0]    scan_mode
);
   logic rd;
   assign rd = bus_req && !bus_we;

   assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> bus_rvalid);
   assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !bus_rvalid && bus_rdata == 32'd0);
   assert_scan_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      scan_req |=> scan_valid);
   assert_scan_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_req |=> !scan_valid);
   assert_w32_top_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_ap == 2'd2) |=> bus_rdata[31:26] == 6'd0);
   assert_w24_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_ap == 2'd1) |=> bus_rdata[31:24] == 8'd0);
   assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_ap == 2'd0) |=> bus_rdata[31:8] == 24'd0);
   assert_none_ap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_ap == 2'd3) |=> bus_rdata == 32'd0);
   assert_size_mismatch_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_ap != 2'd3 && (bus_word == (bus_ap == 2'd0))) |=> bus_rdata == 32'd0);
   assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scan_valid |-> scan_mode != 2'd3);

   logic unused_addr;
   assign unused_addr = ^bus_addr;
endmodule

bind pxs_pixel_store pxs_pixel_store_chk #(.AW(AW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_we     (bus_we),
   .bus_ap     (bus_ap),
   .bus_word   (bus_word),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .scan_req   (scan_req),
   .scan_valid (scan_valid),
   .scan_mode  (scan_mode)
);

// File: tb/pxs_pixel_store_tb.sv
`timescale 1ns/1ps
module pxs_pixel_store_tb_top;
   localparam int H    = 32;
   localparam int V    = 24;
   localparam int NPIX = H * V;
   localparam int IW   = $clog2(NPIX);
   localparam int AW   = IW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
   logic [1:0]    bus_ap = 2'd0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic          scan_req = 1'b0;
   logic [IW-1:0] scan_idx = '0;
   logic          scan_valid;
   logic [23:0]   scan_color;
   logic [1:0]    scan_mode;

   always #5 clk = ~clk;   // 100 MHz

   pxs_pixel_store #(.H_PIX(H), .V_PIX(V)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_ap(bus_ap), .bus_word(bus_word), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .scan_req(scan_req), .scan_idx(scan_idx), .scan_valid(scan_valid),
      .scan_color(scan_color), .scan_mode(scan_mode)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [25:0] model [NPIX];          // expected stored words
   logic [31:0] rq_exp [$];
   string       rq_tag [$];
   logic [25:0] sq_exp [$];            // {decoded mode, colour}
   string       sq_tag [$];

   function automatic logic [1:0] exp_mode(input logic [1:0] m);
      case (m)
         2'b01:   return 2'd1;
         2'b11:   return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

   function automatic logic [23:0] colour_of(input int i);
      return 24'((i * 40503) ^ (i << 13) ^ 24'h5A3C1F);
   endfunction

   function automatic bit in_range(input logic [1:0] ap, input bit word, input int addr);
      if (ap == 2'd0) return !word && addr < NPIX;
      if (ap == 2'd3) return 1'b0;
      return word && addr < 4 * NPIX;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: called at a falling edge, applies one cycle of stimulus
   task automatic op(input bit bdo, input bit we, input logic [1:0] ap, input bit word,
                     input int addr, input logic [31:0] wd,
                     input bit sdo, input int sidx, input string tag);
      int pix;
      bus_req   = bdo;
      bus_we    = we;
      bus_ap    = ap;
      bus_word  = word;
      bus_addr  = AW'(addr);
      bus_wdata = wd;
      scan_req  = sdo;
      scan_idx  = IW'(sidx);
      pix = (ap == 2'd0) ? addr : addr >> 2;
      if (sdo) begin
         sq_exp.push_back({exp_mode(model[sidx][25:24]), model[sidx][23:0]});
         sq_tag.push_back(tag);
      end
      if (bdo && !we) begin
         logic [31:0] e;
         e = '0;
         if (in_range(ap, word, addr)) begin
            case (ap)
               2'd0:    e = {24'd0, model[pix][7:0]};
               2'd1:    e = {8'd0, model[pix][23:0]};
               default: e = {6'd0, model[pix]};
            endcase
         end
         rq_exp.push_back(e);
         rq_tag.push_back(tag);
      end
      if (bdo && we && in_range(ap, word, addr)) begin
         case (ap)
            2'd0:    model[pix][7:0]  = wd[7:0];
            2'd1:    model[pix][23:0] = wd[23:0];
            default: model[pix]       = wd[25:0];
         endcase
      end
      @(negedge clk);
      bus_req  = 1'b0;
      scan_req = 1'b0;
   endtask

   // monitor: pops expectations as results appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (bus_rvalid) begin
            if (rq_exp.size() == 0) check("R9 unexpected read data", 32'd1, 32'd0);
            else check(rq_tag.pop_front(), bus_rdata, rq_exp.pop_front());
         end
         if (scan_valid) begin
            if (sq_exp.size() == 0) check("R5 unexpected scan data", 32'd1, 32'd0);
            else check(sq_tag.pop_front(), {6'd0, scan_mode, scan_color},
                       {6'd0, sq_exp.pop_front()});
         end
      end
   end

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      check("R9 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
      check("R9 scan_valid after reset", {31'd0, scan_valid}, 32'd0);
      check("R9 rdata after reset", bus_rdata, 32'd0);

      // R1: fill every pixel through the full-word aperture, junk in [31:26]
      for (int i = 0; i < NPIX; i++)
         op(1, 1, 2'd2, 1, i * 4 + (i % 4), {6'h2B, 2'(i % 4), colour_of(i)}, 0, 0, "R1 fill");
      // R4/R5: scan every pixel, all mode codes present
      for (int i = 0; i < NPIX; i++)
         op(0, 0, 2'd0, 0, 0, 0, 1, i, "R4 scan decode");
      // cross-aperture reads
      for (int i = 0; i < 16; i++) begin
         op(1, 0, 2'd2, 1, i * 4 + 3, 0, 0, 0, "R1 full-word read");
         op(1, 0, 2'd1, 1, i * 4, 0, 0, 0, "R2 24-bit read");
         op(1, 0, 2'd0, 0, i, 0, 0, 0, "R3 byte read");
      end
      // R2: 24-bit write with all-ones top byte keeps mode
      op(1, 1, 2'd1, 1, 5 * 4, 32'hFF_123456, 0, 0, "R2 write");
      op(1, 0, 2'd2, 1, 5 * 4, 0, 1, 5, "R2 mode kept");
      op(1, 1, 2'd1, 1, 7 * 4, 32'hFF_ABCDEF, 0, 0, "R2 write");
      op(1, 0, 2'd2, 1, 7 * 4, 0, 0, 0, "R2 mode kept");
      // R3: byte write leaves upper 18 bits
      op(1, 1, 2'd0, 0, 6, 32'hFFFF_FFA5, 0, 0, "R3 write");
      op(1, 0, 2'd2, 1, 6 * 4, 0, 1, 6, "R3 upper kept");
      op(1, 1, 2'd0, 0, 11, 32'hFFFF_FF3C, 0, 0, "R3 write");
      op(1, 0, 2'd2, 1, 11 * 4, 0, 0, 0, "R3 upper kept");
      op(1, 0, 2'd0, 0, 11, 0, 0, 0, "R3 byte read");
      // R7: out of range and no-aperture accesses
      op(1, 0, 2'd0, 0, NPIX, 0, 0, 0, "R7 byte oob read");
      op(1, 1, 2'd0, 0, NPIX, 32'h0000_00EE, 0, 0, "R7 byte oob write");
      op(1, 0, 2'd2, 1, 4 * NPIX, 0, 0, 0, "R7 word oob read");
      op(1, 1, 2'd2, 1, 4 * NPIX, 32'h03FF_FFFF, 0, 0, "R7 word oob write");
      op(1, 1, 2'd3, 1, 0, 32'h0000_0000, 0, 0, "R7 none write");
      op(1, 1, 2'd3, 0, 1, 32'h0000_0000, 0, 0, "R7 none write");
      op(1, 0, 2'd3, 1, 0, 0, 0, 0, "R7 none read");
      op(1, 0, 2'd2, 1, 0, 0, 0, 0, "R7 pixel0 kept");
      op(1, 0, 2'd2, 1, 4, 0, 0, 0, "R7 pixel1 kept");
      op(1, 0, 2'd2, 1, (NPIX - 1) * 4, 0, 1, NPIX - 1, "R7 last pixel kept");
      // R8: size mismatches
      op(1, 1, 2'd2, 0, 8, 32'h0000_0000, 0, 0, "R8 byte size on word ap");
      op(1, 1, 2'd1, 0, 9, 32'h0000_0000, 0, 0, "R8 byte size on 24-bit ap");
      op(1, 1, 2'd0, 1, 3, 32'h0000_0000, 0, 0, "R8 word size on byte ap");
      op(1, 0, 2'd2, 0, 8, 0, 0, 0, "R8 mismatched read");
      op(1, 0, 2'd0, 1, 3, 0, 0, 0, "R8 mismatched read");
      op(1, 0, 2'd2, 1, 8, 0, 0, 0, "R8 pixel2 kept");
      op(1, 0, 2'd2, 1, 12, 0, 0, 0, "R8 pixel3 kept");
      // R5: scans alongside bus traffic, back to back
      for (int i = 0; i < 24; i++) begin
         op(1, 1, 2'd2, 1, (100 + i) * 4, {6'd0, 2'(i), colour_of(i + 900)}, 1, 200 + i, "R5 scan with write");
         op(1, 0, 2'd1, 1, (100 + i) * 4, 0, 1, 100 + i, "R5 scan with read");
      end
      // R6: scan and write of the same pixel in one cycle
      op(1, 1, 2'd2, 1, 50 * 4, 32'h0300_0F0F, 1, 50, "R6 old value");
      op(0, 0, 2'd0, 0, 0, 0, 1, 50, "R6 new value");
      op(1, 1, 2'd0, 0, 51, 32'h0000_0077, 1, 51, "R6 old value");
      op(0, 0, 2'd0, 0, 0, 0, 1, 51, "R6 new value");
      // R4: reserved code and clearing modes back to indexed
      op(1, 1, 2'd2, 1, 60 * 4, 32'h0212_3456, 0, 0, "R4 reserved write");
      op(0, 0, 2'd0, 0, 0, 0, 1, 60, "R4 reserved decodes as index");
      for (int i = 0; i < 8; i++) begin
         op(1, 1, 2'd2, 1, i * 4, {8'd0, model[i][23:0]}, 0, 0, "R4 clear mode");
         op(0, 0, 2'd0, 0, 0, 0, 1, i, "R4 cleared to index");
      end
      repeat (3) @(negedge clk);
      if (rq_exp.size() != 0) check("R9 missing read data", 32'(rq_exp.size()), 32'd0);
      if (sq_exp.size() != 0) check("R5 missing scan data", 32'(sq_exp.size()), 32'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule